// File: doc/BRIEF.md
# Pulse-Coded Isolation Channel Codec

This block moves one synchronous logic signal across a barrier that can only carry short pulses. The sending half watches the input level. On each rising transition it emits a one-cycle pulse on a "set" line, and on each falling transition a one-cycle pulse on a "clear" line. When the input stays quiet for a programmable number of cycles, it repeats a pulse that reports the present level. A level is therefore never held on a line.

The receiving half is a set/clear latch that follows those pulses and holds its state between them. A missing-pulse watchdog sits beside the latch. If nothing arrives within a programmable timeout, the watchdog declares the link lost and the output falls to a per-instance failsafe level. The first pulse after such a loss restores normal decoding at once.

Both halves sit in one module. The encoder outputs and the decoder inputs are separate ports, so the barrier (or a fault on it) can be modelled between them.

Top module: `iso_pulse_codec`

## Requirements
- R1: A rising transition of `tx_data` produces `tx_set` high for exactly one cycle, one clock after the transition is sampled. A falling transition produces `tx_clr` the same way.
- R2: Every pulse lasts one cycle, and `tx_set` and `tx_clr` are never high together. While `tx_data` is constant, pulses appear only at the refresh spacing, never continuously.
- R3: After `REFRESH_CYCLES` cycles with no transition, the encoder emits a refresh pulse of the current level (`tx_set` when the input is 1, `tx_clr` when it is 0). Any pulse, edge or refresh, restarts that interval.
- R4: A lone `rx_set` makes the decoded level 1 and a lone `rx_clr` makes it 0, from the next clock. The level is held between pulses.
- R5: When `rx_set` and `rx_clr` are high in the same cycle, the decoded level is left unchanged.
- R6: If no pulse is received for `TIMEOUT_CYCLES` consecutive clocks, `link_ok` goes low and `rx_data` shows `DEFAULT_LEVEL`. `link_ok` drops exactly `TIMEOUT_CYCLES` clocks after the clock that sampled the last pulse.
- R7: Any received pulse sets `link_ok` on the next clock. After a loss, a lone pulse brings `rx_data` to the pulse's level on that same clock.
- R8: After reset, `link_ok` is 0, `rx_data` equals `DEFAULT_LEVEL`, and neither encoder line pulses before the first transition or refresh.
- R9: The failsafe level is a per-instance parameter (`DEFAULT_LEVEL`, 1 or 0). Two instances with different values show their own level while no pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both halves |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_data | input | 1 | Signal to be carried across the barrier |
| tx_set | output | 1 | Encoder pulse reporting a high level or a rising edge |
| tx_clr | output | 1 | Encoder pulse reporting a low level or a falling edge |
| rx_set | input | 1 | Received set pulse from the barrier |
| rx_clr | input | 1 | Received clear pulse from the barrier |
| rx_data | output | 1 | Decoded signal, or `DEFAULT_LEVEL` while the link is lost |
| link_ok | output | 1 | High while pulses keep arriving within the timeout |

## Verification
The encoder is looped back to the decoder. It is driven with short alternating holds, which show edge-pulse latency and polarity. It is also driven with holds longer than the timeout, which show that refresh pulses alone keep the link alive and the level correct. A cycle-by-cycle walk after an edge checks that the refresh falls exactly one interval later, and that an edge in mid-interval pushes it back. Separately, the barrier is cut and single pulses are injected by hand. This separates three cases: watchdog expiry at its exact cycle, instant recovery on the next pulse, and a simultaneous set/clear pair that must leave the level alone. A second instance with the opposite failsafe level, given no pulses, tells a per-instance default apart from a fixed one.

// File: rtl/iso_codec_pkg.sv
// Package: shared types for the pulse-coded isolation codec.
// Assumes: one channel per codec instance; a pulse is one clock long.
package iso_codec_pkg;

    // A pair of barrier lines: set reports "high", clr reports "low".
    typedef struct packed {
        logic set;
        logic clr;
    } pulse_pair_t;

endpackage

// File: rtl/iso_edge_encoder.sv
// Module: iso_edge_encoder
// Turns a level into one-cycle pulses. An input edge sends a pulse of the new
// level. A quiet interval of REFRESH_CYCLES sends a repeat pulse of the present
// level. Any pulse restarts the interval.
// Assumes: din is synchronous to clk; REFRESH_CYCLES >= 2.
module iso_edge_encoder
    import iso_codec_pkg::*;
#(
    parameter int REFRESH_CYCLES = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        din,
    output pulse_pair_t pulse
);

    localparam int CW = $clog2(REFRESH_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(REFRESH_CYCLES - 1);

    logic          din_prev;
    logic [CW-1:0] quiet_cnt;
    logic          edge_seen;
    logic          refresh_due;
    logic          fire;

    assign edge_seen   = din ^ din_prev;
    assign refresh_due = (quiet_cnt == LAST);
    assign fire        = edge_seen | refresh_due;

    // Track the previous level. It is not cleared by reset, so no false edge
    // appears when reset is released.
    always_ff @(posedge clk) begin
        din_prev <= din;
    end

    // Count quiet cycles and emit an edge or refresh pulse of the current level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
            pulse     <= '0;
        end else if (fire) begin
            quiet_cnt <= '0;
            pulse.set <= din;
            pulse.clr <= ~din;
        end else begin
            quiet_cnt <= quiet_cnt + 1'b1;
            pulse     <= '0;
        end
    end

    // R1
    edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (din != $past(din)) |=> (pulse.set || pulse.clr));

    // R3
    set_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse.set |-> $past(din));

    // R3
    refresh_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_cnt < CW'(REFRESH_CYCLES));

endmodule

// File: rtl/iso_sr_decoder.sv
// Module: iso_sr_decoder
// Bistable latch driven by received pulses: a lone set gives 1, a lone clr
// gives 0, and a simultaneous pair is ignored. It holds its state between pulses.
// Assumes: pulses are already synchronous to clk.
module iso_sr_decoder
    import iso_codec_pkg::*;
#(
    parameter bit RESET_LEVEL = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  pulse_pair_t pulse,
    output logic        level
);

    // Update the latched level from a lone set or a lone clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= RESET_LEVEL;
        end else begin
            case ({pulse.set, pulse.clr})
                2'b10:   level <= 1'b1;
                2'b01:   level <= 1'b0;
                default: level <= level;
            endcase
        end
    end

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse.set && !pulse.clr) |=> level);

    // R4
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse.clr && !pulse.set) |=> !level);

    // R5
    conflict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse.set && pulse.clr) |=> $stable(level));

endmodule

// File: rtl/iso_link_watchdog.sv
// Module: iso_link_watchdog
// Declares the link lost when no pulse has arrived for TIMEOUT_CYCLES clocks.
// Any pulse restores it on the next clock.
// Assumes: TIMEOUT_CYCLES >= 2; link is reported lost from reset.
module iso_link_watchdog #(
    parameter int TIMEOUT_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_seen,
    output logic link_ok
);

    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYCLES - 1);

    logic [TW-1:0] silent_cnt;

    // Restart on any pulse; drop the link when the silent count reaches the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            silent_cnt <= '0;
            link_ok    <= 1'b0;
        end else if (pulse_seen) begin
            silent_cnt <= '0;
            link_ok    <= 1'b1;
        end else if (silent_cnt == LAST) begin
            link_ok    <= 1'b0;
        end else begin
            silent_cnt <= silent_cnt + 1'b1;
        end
    end

    // R7
    pulse_revives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_seen |=> link_ok);

    // R6
    drop_only_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_ok) |-> !$past(pulse_seen));

endmodule

// File: rtl/iso_pulse_codec.sv
// Module: iso_pulse_codec (top)
// One channel of a pulse-only isolation link. The encoder drives tx_set/tx_clr.
// The decoder and watchdog take rx_set/rx_clr and produce rx_data and link_ok.
// rx_data is DEFAULT_LEVEL whenever the link is lost.
// Assumes: TIMEOUT_CYCLES > REFRESH_CYCLES, so a healthy link never times out.
module iso_pulse_codec
    import iso_codec_pkg::*;
#(
    parameter int REFRESH_CYCLES = 100,
    parameter int TIMEOUT_CYCLES = 500,
    parameter bit DEFAULT_LEVEL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_data,
    output logic tx_set,
    output logic tx_clr,
    input  logic rx_set,
    input  logic rx_clr,
    output logic rx_data,
    output logic link_ok
);

    pulse_pair_t enc_pulse;
    pulse_pair_t dec_pulse;
    logic        latched;

    // Check the interval ordering once at start-up.
    initial begin
        assert (TIMEOUT_CYCLES > REFRESH_CYCLES)
            else $error("timeout must exceed refresh interval");
    end

    iso_edge_encoder #(
        .REFRESH_CYCLES(REFRESH_CYCLES)
    ) u_enc (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (tx_data),
        .pulse(enc_pulse)
    );

    assign tx_set        = enc_pulse.set;
    assign tx_clr        = enc_pulse.clr;
    assign dec_pulse.set = rx_set;
    assign dec_pulse.clr = rx_clr;

    iso_sr_decoder #(
        .RESET_LEVEL(DEFAULT_LEVEL)
    ) u_dec (
        .clk  (clk),
        .rst_n(rst_n),
        .pulse(dec_pulse),
        .level(latched)
    );

    iso_link_watchdog #(
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) u_wdg (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_seen(rx_set | rx_clr),
        .link_ok   (link_ok)
    );

    // Choose the failsafe level while the link is lost.
    always_comb begin
        rx_data = link_ok ? latched : DEFAULT_LEVEL;
    end

    // R2
    tx_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_set && tx_clr));

    // R6
    lost_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_ok && !rx_set && !rx_clr) |=> (rx_data == DEFAULT_LEVEL));

endmodule

// File: tb/test_iso_pulse_codec.sv
// Bench for iso_pulse_codec: a looped-back vector table, then directed tests
// of refresh timing, timeout, recovery, conflicting pulses and per-instance default.
module test_iso_pulse_codec;

    localparam int RCY = 8;
    localparam int TCY = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_data = 1'b0;
    logic tx_set, tx_clr, rx_data, link_ok;
    logic link_en = 1'b1;
    logic inj_set = 1'b0;
    logic inj_clr = 1'b0;
    logic alt_set, alt_clr, alt_rx, alt_link;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   both_seen = 1'b0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    iso_pulse_codec #(
        .REFRESH_CYCLES(RCY), .TIMEOUT_CYCLES(TCY), .DEFAULT_LEVEL(1'b1)
    ) i_iso_pulse_codec (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data),
        .tx_set(tx_set), .tx_clr(tx_clr),
        .rx_set((tx_set & link_en) | inj_set),
        .rx_clr((tx_clr & link_en) | inj_clr),
        .rx_data(rx_data), .link_ok(link_ok)
    );

    iso_pulse_codec #(
        .REFRESH_CYCLES(RCY), .TIMEOUT_CYCLES(TCY), .DEFAULT_LEVEL(1'b0)
    ) i_alt_codec (
        .clk(clk), .rst_n(rst_n), .tx_data(1'b0),
        .tx_set(alt_set), .tx_clr(alt_clr),
        .rx_set(1'b0), .rx_clr(1'b0),
        .rx_data(alt_rx), .link_ok(alt_link)
    );

    // Entry: {din, hold cycles[6:0], expected rx_data, expected link_ok}
    localparam logic [9:0] VEC [7] = '{
        {1'b1, 7'd3,  1'b1, 1'b1},
        {1'b0, 7'd3,  1'b0, 1'b1},
        {1'b1, 7'd2,  1'b1, 1'b1},
        {1'b0, 7'd12, 1'b0, 1'b1},
        {1'b1, 7'd45, 1'b1, 1'b1},
        {1'b0, 7'd50, 1'b0, 1'b1},
        {1'b1, 7'd2,  1'b1, 1'b1}
    };

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Note any cycle with both encoder lines high (R2).
    always @(negedge clk) begin
        if (rst_n && tx_set && tx_clr) both_seen = 1'b1;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int pulses;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R8: state right after reset
        check("R8", "link_ok", link_ok, 1'b0);
        check("R8", "rx_data", rx_data, 1'b1);
        check("R8", "tx_set", tx_set, 1'b0);
        check("R8", "tx_clr", tx_clr, 1'b0);
        // R9: second instance with opposite failsafe level
        check("R9", "alt rx_data", alt_rx, 1'b0);
        check("R9", "alt link_ok", alt_link, 1'b0);

        // Vector walk through the looped-back link (R1, R3, R4)
        for (int i = 0; i < 7; i++) begin
            tx_data = VEC[i][9];
            tick(int'(VEC[i][8:2]));
            check("R4", $sformatf("vec%0d rx_data", i), rx_data, VEC[i][1]);
            check("R3", $sformatf("vec%0d link_ok", i), link_ok, VEC[i][0]);
        end
        tick(RCY + 2);

        // R1/R3: edge pulse timing, then exact refresh spacing
        tx_data = 1'b0;
        tick(1);
        check("R1", "falling edge tx_clr", tx_clr, 1'b1);
        check("R1", "falling edge no tx_set", tx_set, 1'b0);
        pulses = 0;
        for (int j = 0; j < RCY - 1; j++) begin
            tick(1);
            if (tx_set || tx_clr) pulses++;
        end
        check("R2", "quiet between pulses", pulses == 0, 1'b1);
        tick(1);
        check("R3", "refresh low polarity", tx_clr, 1'b1);
        tick(1);
        check("R2", "refresh one cycle", tx_clr, 1'b0);
        tick(2);
        tx_data = 1'b1;
        tick(1);
        check("R1", "rising edge tx_set", tx_set, 1'b1);
        tick(RCY - 4);
        check("R3", "edge restarts interval", tx_set | tx_clr, 1'b0);
        tick(4);
        check("R3", "refresh high polarity", tx_set, 1'b1);

        // R2: pulse count over a constant window
        pulses = 0;
        for (int j = 0; j < 4 * RCY; j++) begin
            tick(1);
            if (tx_set || tx_clr) pulses++;
        end
        check("R2", "pulses per window is 4", pulses == 4, 1'b1);

        // R6: cut the barrier with level 0 latched
        tx_data = 1'b0;
        tick(3);
        check("R4", "level 0 before cut", rx_data, 1'b0);
        link_en = 1'b0;
        tick(TCY + 10);
        check("R6", "link lost", link_ok, 1'b0);
        check("R6", "default shown", rx_data, 1'b1);

        // R7: a lone injected clear restores decoding at once
        inj_clr = 1'b1;
        tick(1);
        inj_clr = 1'b0;
        check("R7", "recovered link_ok", link_ok, 1'b1);
        check("R7", "recovered rx_data", rx_data, 1'b0);
        pulses = 0;
        for (int j = 1; j < TCY; j++) begin
            tick(1);
            if (!link_ok) pulses++;
        end
        check("R6", "link held until timeout", pulses == 0, 1'b1);
        tick(1);
        check("R6", "drop at exact timeout", link_ok, 1'b0);
        check("R6", "default after timeout", rx_data, 1'b1);

        // R5: simultaneous set and clear leave the level alone
        inj_clr = 1'b1;
        tick(1);
        inj_set = 1'b1;
        tick(1);
        inj_set = 1'b0;
        inj_clr = 1'b0;
        check("R5", "conflict keeps 0", rx_data, 1'b0);
        check("R5", "conflict keeps link", link_ok, 1'b1);
        tick(3);
        check("R4", "held between pulses", rx_data, 1'b0);
        inj_set = 1'b1;
        tick(1);
        inj_set = 1'b0;
        check("R4", "lone set gives 1", rx_data, 1'b1);

        check("R2", "never both lines high", both_seen, 1'b0);
        check("R9", "alt still default", alt_rx, 1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule